// File: doc/BRIEF.md
# Endpoint-0 Control Transfer Status Register

This block holds the handshake state for the default control endpoint of a USB device controller. It sits between a byte-wide firmware register bus and the packet engine. The flags in its status byte follow four access patterns. Two bits are write-one clear commands that always read back as zero. Some flags are requests that firmware raises and the engine retires. Some flags are events that the engine raises and that firmware clears only through a companion command bit. One flag is a sticky stall report that firmware clears by writing zero to it.

The register is reached through a small endpoint-select register. The status byte is visible only while endpoint 0 is selected. The block drives the stall request, the packet-ready and data-end state, and a flush command to the packet engine. It also raises a one-cycle interrupt pulse whenever the engine reports an event that sets a flag or retires a loaded IN packet.

The data-end flag closes the data stage of a control transfer. Firmware must write it in the same byte as the packet-ready bit, which covers both the last IN packet and a zero-length IN packet. It may instead be written in the same byte as the clear-received command, for the last OUT packet. The flag drops when the engine reports that the transfer stage has completed.

Top module: `ep0_ctrl_csr`

## Requirements
- R1: After reset every status bit reads 0, the endpoint select reads 0, and stall_o, in_rdy_o, data_end_o, flush_o and irq_o are low.
- R2: Address 1 is the status byte. Reads and writes at this address reach it only while the endpoint select (address 0, low 4 bits) holds 0. Otherwise the status byte reads 0x00 and writes to it change nothing.
- R3: A write to the endpoint select takes effect only when the whole written byte is at most 5. A larger byte is ignored and the old value is kept.
- R4: Bit 7 and bit 6 of the status byte are clear commands. Writing 1 to bit 7 clears the setup-end flag (bit 4), and writing 1 to bit 6 clears the received flag (bit 0). Both command bits always read 0.
- R5: Writing 1 to bit 5 raises the stall request, which is driven on stall_o. A stall-sent event clears bit 5 one cycle later and sets the stall-sent flag in bit 2.
- R6: Bit 2 is cleared only by a status write with bit 2 at 0. A write with bit 2 at 1 leaves it set.
- R7: A premature-end event sets bit 4, gives a one-cycle flush_o pulse in the following cycle, and clears bits 1 and 3.
- R8: Writing 1 to bit 1 raises packet-ready (in_rdy_o). An IN-sent event clears it.
- R9: Bit 0 is set by a packet-received event. Writes that set bit 0 or bit 4 directly have no effect.
- R10: Writing 1 to bit 3 sets data-end only when the same write also has bit 1 or bit 6 at 1. Otherwise the write is ignored. A stage-done event clears data-end.
- R11: irq_o pulses for one cycle, in the cycle after any premature-end, packet-received or stall-sent event, and after an IN-sent event while packet-ready was set. It pulses only when irq_en_i was high in the event cycle.
- R12: When an engine event sets a flag in the same cycle as a firmware command clears that flag, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 1 | Register select: 0 endpoint select, 1 status byte |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_en_i | input | 1 | Endpoint-0 interrupt enable |
| pe_setup_end_i | input | 1 | Engine: control transfer ended prematurely |
| pe_out_rcvd_i | input | 1 | Engine: OUT packet placed in FIFO |
| pe_in_sent_i | input | 1 | Engine: IN packet transmitted |
| pe_stall_sent_i | input | 1 | Engine: STALL handshake sent |
| pe_stage_done_i | input | 1 | Engine: data stage completed |
| stall_o | output | 1 | Stall request to the engine |
| in_rdy_o | output | 1 | IN packet loaded and ready |
| data_end_o | output | 1 | Last data packet of the stage |
| flush_o | output | 1 | One-cycle FIFO flush command |
| irq_o | output | 1 | One-cycle endpoint-0 interrupt request |

## Verification
Status writes are tried with each access type in turn. A command bit that should clear, a request bit that should set, and a direct write to a hardware-owned bit are each read back, so that a missing decode can be told apart from a wrong owner. Data-end is written both alone and paired with each of the two legal companion bits, which separates the gated set from an ungated one. Engine events are fired with interrupts enabled and disabled, and IN-sent is fired with packet-ready both set and clear. Firmware clears are issued in the same cycle as engine sets to expose the wrong priority. Accesses with a nonzero or out-of-range endpoint select show that the status byte is gated.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int DATA_W = 8;

  localparam int B_CLR_SETUP  = 7;
  localparam int B_CLR_OUT    = 6;
  localparam int B_STALL      = 5;
  localparam int B_SETUP_END  = 4;
  localparam int B_DATA_END   = 3;
  localparam int B_SENT_STALL = 2;
  localparam int B_IN_RDY     = 1;
  localparam int B_OUT_RDY    = 0;

  // firmware intents decoded from one status-byte write
  typedef struct packed {
    logic clr_setup;
    logic clr_out;
    logic set_stall;
    logic set_data_end;
    logic clr_sent;
    logic set_in_rdy;
  } cs_wr_t;

  typedef struct packed {
    logic setup_end;
    logic out_rcvd;
    logic in_sent;
    logic stall_sent;
    logic stage_done;
  } pe_evt_t;
endpackage

// File: rtl/ep0_index_reg.sv
module ep0_index_reg #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4,
  parameter int NUM_EP = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              is_ep0_o
);
  localparam int MAX_IDX = NUM_EP - 1;

  logic [IDX_W-1:0] idx_q;
  logic             legal;

  assign legal = (int'(wdata_i) <= MAX_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           idx_q <= '0;
    else if (wr_i && legal) idx_q <= wdata_i[IDX_W-1:0];
  end

  assign idx_o    = idx_q;
  assign is_ep0_o = (idx_q == '0);

  a_r3_idx_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) <= MAX_IDX);
  a_r3_illegal_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !legal) |=> $stable(idx_q));
endmodule

// File: rtl/ep0_fw_flags.sv
module ep0_fw_flags
  import ep0_csr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cs_wr_t  cs_wr_i,
  input  pe_evt_t evt_i,
  output logic    stall_o,
  output logic    data_end_o,
  output logic    in_rdy_o,
  output logic    in_done_o
);
  logic stall_q, data_end_q, in_rdy_q;
  logic de_accept;

  // data-end only counts alongside a packet hand-off
  assign de_accept = cs_wr_i.set_data_end & (cs_wr_i.set_in_rdy | cs_wr_i.clr_out);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_q    <= 1'b0;
      data_end_q <= 1'b0;
      in_rdy_q   <= 1'b0;
    end else begin
      if (evt_i.stall_sent)     stall_q <= 1'b0;
      else if (cs_wr_i.set_stall) stall_q <= 1'b1;

      if (evt_i.setup_end)      data_end_q <= 1'b0;
      else if (de_accept)       data_end_q <= 1'b1;
      else if (evt_i.stage_done) data_end_q <= 1'b0;

      if (evt_i.setup_end)       in_rdy_q <= 1'b0;
      else if (cs_wr_i.set_in_rdy) in_rdy_q <= 1'b1;
      else if (evt_i.in_sent)    in_rdy_q <= 1'b0;
    end
  end

  assign stall_o    = stall_q;
  assign data_end_o = data_end_q;
  assign in_rdy_o   = in_rdy_q;
  assign in_done_o  = evt_i.in_sent & in_rdy_q;

  a_r5_stall_retired: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.stall_sent |=> !stall_q);
  a_r7_flush_drops_requests: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.setup_end |=> (!in_rdy_q && !data_end_q));
  a_r10_lone_data_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_wr_i.set_data_end && !cs_wr_i.set_in_rdy && !cs_wr_i.clr_out && !data_end_q)
    |=> !data_end_q);
endmodule

// File: rtl/ep0_hw_flags.sv
module ep0_hw_flags
  import ep0_csr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  cs_wr_t  cs_wr_i,
  input  pe_evt_t evt_i,
  output logic    setup_end_o,
  output logic    out_rdy_o,
  output logic    sent_stall_o
);
  logic setup_end_q, out_rdy_q, sent_stall_q;

  // engine set beats firmware clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      setup_end_q  <= 1'b0;
      out_rdy_q    <= 1'b0;
      sent_stall_q <= 1'b0;
    end else begin
      if (evt_i.setup_end)       setup_end_q <= 1'b1;
      else if (cs_wr_i.clr_setup) setup_end_q <= 1'b0;

      if (evt_i.out_rcvd)        out_rdy_q <= 1'b1;
      else if (cs_wr_i.clr_out)  out_rdy_q <= 1'b0;

      if (evt_i.stall_sent)      sent_stall_q <= 1'b1;
      else if (cs_wr_i.clr_sent) sent_stall_q <= 1'b0;
    end
  end

  assign setup_end_o  = setup_end_q;
  assign out_rdy_o    = out_rdy_q;
  assign sent_stall_o = sent_stall_q;

  a_r12_out_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.out_rcvd |=> out_rdy_q);
  a_r12_setup_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.setup_end |=> setup_end_q);
  a_r6_sent_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sent_stall_q && !cs_wr_i.clr_sent) |=> sent_stall_q);
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen
  import ep0_csr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  pe_evt_t evt_i,
  input  logic    in_done_i,
  input  logic    irq_en_i,
  output logic    irq_o,
  output logic    flush_o
);
  logic irq_q, flush_q, any_evt;

  assign any_evt = evt_i.setup_end | evt_i.out_rcvd | evt_i.stall_sent | in_done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      irq_q   <= irq_en_i & any_evt;
      flush_q <= evt_i.setup_end;
    end
  end

  assign irq_o   = irq_q;
  assign flush_o = flush_q;

  a_r11_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(irq_en_i));
  a_r11_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |=> !irq_q);
endmodule

// File: rtl/ep0_ctrl_csr.sv
module ep0_ctrl_csr
  import ep0_csr_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int NUM_EP   = 6,
  parameter int ADDR_W   = 1,
  parameter int IDX_ADDR = 0,
  parameter int CS_ADDR  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              irq_en_i,
  input  logic              pe_setup_end_i,
  input  logic              pe_out_rcvd_i,
  input  logic              pe_in_sent_i,
  input  logic              pe_stall_sent_i,
  input  logic              pe_stage_done_i,
  output logic              stall_o,
  output logic              in_rdy_o,
  output logic              data_end_o,
  output logic              flush_o,
  output logic              irq_o
);
  logic             sel_idx, sel_cs, is_ep0, cs_access;
  logic [IDX_W-1:0] idx;
  cs_wr_t           cs_wr;
  pe_evt_t          evt;
  logic             setup_end, out_rdy, sent_stall, in_done;
  logic             stall, data_end, in_rdy;
  logic [DATA_W-1:0] cs_byte;

  assign sel_idx   = (int'(addr_i) == IDX_ADDR);
  assign sel_cs    = (int'(addr_i) == CS_ADDR);
  assign cs_access = wr_en_i & sel_cs & is_ep0;

  always_comb begin
    cs_wr.clr_setup    = cs_access & wdata_i[B_CLR_SETUP];
    cs_wr.clr_out      = cs_access & wdata_i[B_CLR_OUT];
    cs_wr.set_stall    = cs_access & wdata_i[B_STALL];
    cs_wr.set_data_end = cs_access & wdata_i[B_DATA_END];
    cs_wr.clr_sent     = cs_access & ~wdata_i[B_SENT_STALL];
    cs_wr.set_in_rdy   = cs_access & wdata_i[B_IN_RDY];
  end

  always_comb begin
    evt.setup_end  = pe_setup_end_i;
    evt.out_rcvd   = pe_out_rcvd_i;
    evt.in_sent    = pe_in_sent_i;
    evt.stall_sent = pe_stall_sent_i;
    evt.stage_done = pe_stage_done_i;
  end

  ep0_index_reg #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NUM_EP(NUM_EP)) u_index (
    .clk_i, .rst_ni,
    .wr_i     (wr_en_i & sel_idx),
    .wdata_i  (wdata_i),
    .idx_o    (idx),
    .is_ep0_o (is_ep0)
  );

  ep0_fw_flags u_fw (
    .clk_i, .rst_ni,
    .cs_wr_i    (cs_wr),
    .evt_i      (evt),
    .stall_o    (stall),
    .data_end_o (data_end),
    .in_rdy_o   (in_rdy),
    .in_done_o  (in_done)
  );

  ep0_hw_flags u_hw (
    .clk_i, .rst_ni,
    .cs_wr_i      (cs_wr),
    .evt_i        (evt),
    .setup_end_o  (setup_end),
    .out_rdy_o    (out_rdy),
    .sent_stall_o (sent_stall)
  );

  ep0_irq_gen u_irq (
    .clk_i, .rst_ni,
    .evt_i     (evt),
    .in_done_i (in_done),
    .irq_en_i  (irq_en_i),
    .irq_o     (irq_o),
    .flush_o   (flush_o)
  );

  always_comb begin
    cs_byte               = '0;
    cs_byte[B_STALL]      = stall;
    cs_byte[B_SETUP_END]  = setup_end;
    cs_byte[B_DATA_END]   = data_end;
    cs_byte[B_SENT_STALL] = sent_stall;
    cs_byte[B_IN_RDY]     = in_rdy;
    cs_byte[B_OUT_RDY]    = out_rdy;
  end

  always_comb begin
    rdata_o = '0;
    if (sel_idx)              rdata_o[IDX_W-1:0] = idx;
    else if (sel_cs && is_ep0) rdata_o = cs_byte;
  end

  assign stall_o    = stall;
  assign in_rdy_o   = in_rdy;
  assign data_end_o = data_end;

  a_r7_flush_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pe_setup_end_i |=> (flush_o && setup_end));
  a_r2_gated_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && sel_cs && !is_ep0 && !pe_stall_sent_i && !pe_setup_end_i)
    |=> $stable(stall_o));
  a_r4_cmd_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_cs |-> (rdata_o[B_CLR_SETUP] == 1'b0 && rdata_o[B_CLR_OUT] == 1'b0));
endmodule

// File: tb/ep0_ctrl_csr_bench.sv
`timescale 1ns/1ps
module ep0_ctrl_csr_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [0:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_en = 1'b1;
  logic       ev_setup = 0, ev_out = 0, ev_in = 0, ev_stall = 0, ev_done = 0;
  logic       stall, in_rdy, data_end, flush, irq;
  int         checks = 0, fails = 0;

  always #10 clk = ~clk;

  ep0_ctrl_csr u_ep0_ctrl_csr (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wdata_i(wdata),
    .rdata_o(rdata), .irq_en_i(irq_en), .pe_setup_end_i(ev_setup),
    .pe_out_rcvd_i(ev_out), .pe_in_sent_i(ev_in), .pe_stall_sent_i(ev_stall),
    .pe_stage_done_i(ev_done), .stall_o(stall), .in_rdy_o(in_rdy),
    .data_end_o(data_end), .flush_o(flush), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // one cycle of write and/or events; events bits {setup,out,in,stall,done}
  task automatic cyc(input logic we, input logic a, input logic [7:0] d, input logic [4:0] ev);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d;
    {ev_setup, ev_out, ev_in, ev_stall, ev_done} = ev;
    @(negedge clk);
    wr_en = 1'b0;
    {ev_setup, ev_out, ev_in, ev_stall, ev_done} = '0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    cyc(1'b1, a, d, 5'b0);
  endtask

  task automatic fire(input logic [4:0] ev);
    cyc(1'b0, 1'b0, 8'h00, ev);
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b1, v); chk("R1 status", v, 8'h00);
    rd(1'b0, v); chk("R1 index", v, 8'h00);
    chk("R1 outputs", {3'b0, stall, in_rdy, data_end, flush, irq}, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] v;
    wr(1'b0, 8'h03); rd(1'b0, v); chk("R3 index legal", v, 8'h03);
    wr(1'b1, 8'h22); rd(1'b1, v); chk("R2 status hidden", v, 8'h00);
    chk("R2 write blocked", {6'b0, stall, in_rdy}, 8'h00);
    wr(1'b0, 8'h07); rd(1'b0, v); chk("R3 index 7 ignored", v, 8'h03);
    wr(1'b0, 8'h15); rd(1'b0, v); chk("R3 index 0x15 ignored", v, 8'h03);
    wr(1'b0, 8'h00); rd(1'b1, v); chk("R2 status back", v, 8'h00);
  endtask

  task automatic t_stall();
    logic [7:0] v;
    wr(1'b1, 8'h24); rd(1'b1, v); chk("R5 stall set", v, 8'h20);
    chk("R5 stall_o", {7'b0, stall}, 8'h01);
    fire(5'b00010);
    chk("R11 irq stall", {7'b0, irq}, 8'h01);
    rd(1'b1, v); chk("R5 stall retired", v, 8'h04);
    idle(); chk("R11 irq one cycle", {7'b0, irq}, 8'h00);
    wr(1'b1, 8'h04); rd(1'b1, v); chk("R6 write 1 keeps", v, 8'h04);
    wr(1'b1, 8'h00); rd(1'b1, v); chk("R6 write 0 clears", v, 8'h00);
  endtask

  task automatic t_in();
    logic [7:0] v;
    wr(1'b1, 8'h06); rd(1'b1, v); chk("R8 in_rdy set", v, 8'h02);
    chk("R8 in_rdy_o", {7'b0, in_rdy}, 8'h01);
    fire(5'b00100);
    chk("R11 irq in sent", {7'b0, irq}, 8'h01);
    rd(1'b1, v); chk("R8 in_rdy cleared", v, 8'h00);
    fire(5'b00100);
    chk("R11 no irq idle in", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_out();
    logic [7:0] v;
    fire(5'b01000);
    chk("R11 irq out", {7'b0, irq}, 8'h01);
    rd(1'b1, v); chk("R9 out set", v, 8'h01);
    wr(1'b1, 8'h15); rd(1'b1, v); chk("R9 direct write ignored", v, 8'h01);
    wr(1'b1, 8'h44); rd(1'b1, v); chk("R4 clear out", v, 8'h00);
    wr(1'b1, 8'h14); rd(1'b1, v); chk("R9 setup bit ignored", v, 8'h00);
  endtask

  task automatic t_setup();
    logic [7:0] v;
    wr(1'b1, 8'h0E); rd(1'b1, v); chk("R10 data end with in", v, 8'h0A);
    fire(5'b10000);
    chk("R7 flush", {7'b0, flush}, 8'h01);
    chk("R11 irq setup", {7'b0, irq}, 8'h01);
    rd(1'b1, v); chk("R7 flags", v, 8'h10);
    idle(); chk("R7 flush one cycle", {7'b0, flush}, 8'h00);
    wr(1'b1, 8'hC4); rd(1'b1, v); chk("R4 clear setup", v, 8'h00);
  endtask

  task automatic t_data_end();
    logic [7:0] v;
    wr(1'b1, 8'h0C); rd(1'b1, v); chk("R10 lone ignored", v, 8'h00);
    fire(5'b01000);
    wr(1'b1, 8'h4C); rd(1'b1, v); chk("R10 data end with clear", v, 8'h08);
    chk("R10 data_end_o", {7'b0, data_end}, 8'h01);
    fire(5'b00001); rd(1'b1, v); chk("R10 stage done clears", v, 8'h00);
  endtask

  task automatic t_collide();
    logic [7:0] v;
    fire(5'b01000);
    cyc(1'b1, 1'b1, 8'h44, 5'b01000); rd(1'b1, v); chk("R12 out wins", v, 8'h01);
    wr(1'b1, 8'h44);
    fire(5'b10000);
    cyc(1'b1, 1'b1, 8'h84, 5'b10000); rd(1'b1, v); chk("R12 setup wins", v, 8'h10);
    wr(1'b1, 8'h84);
    cyc(1'b1, 1'b1, 8'h00, 5'b00010); rd(1'b1, v); chk("R12 sent wins", v, 8'h04);
    wr(1'b1, 8'h00); rd(1'b1, v); chk("R12 cleanup", v, 8'h00);
  endtask

  task automatic t_irq_off();
    logic [7:0] v;
    irq_en = 1'b0;
    fire(5'b01000);
    chk("R11 masked", {7'b0, irq}, 8'h00);
    rd(1'b1, v); chk("R11 flag still set", v, 8'h01);
    irq_en = 1'b1;
    wr(1'b1, 8'h44);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle();
    t_reset();
    t_index();
    t_stall();
    t_in();
    t_out();
    t_setup();
    t_data_end();
    t_collide();
    t_irq_off();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule